// File: doc/BRIEF.md
# Parallel Flash Word Reader

This block reads words from an external parallel Flash or EEPROM and hands them to an internal memory-space client. A request carries a byte address and a tag for the memory space it serves. The block runs one or more read cycles on the external bus and packs the returned bytes into one logical word. A logical word is 1, 2 or 4 bytes. The physical bus is 8 or 16 bits wide. The two settings are independent, so the number of bus cycles and the byte placement depend on the pair. Each bus cycle holds the address and output-enable for a programmable number of wait cycles before the data is sampled. Two active-low chip selects let two devices share the bus without outside decode logic.

Requests and responses use valid/ready. `req_ready` is high only when no access is in flight, so the X, Y and P clients are served strictly one after another. A response stays on `rsp_valid`/`rsp_data` until `rsp_ready` takes it. While a response waits, no new request is accepted, so back-pressure from the client stalls the request side. The configuration pins are plain levels and are sampled when a request is accepted.

Top module: `pflash_word_rd`

## Requirements
- R1: `req_ready` is 1 only when the block is idle. It is 0 from the accepting edge (`req_valid & req_ready`) until the response handshake completes.
- R2: While `rsp_valid` is 1 and `rsp_ready` is 0, `rsp_valid`, `rsp_data` and `rsp_space` hold steady. On the edge where both are 1, the block returns to idle.
- R3: The word-size code is 0 for 1 byte, 1 for 2 bytes, and 2 or 3 for 4 bytes. `cfg_bus16`=1 selects a 16-bit bus. The number of bus cycles per word is word bytes divided by bus bytes, at least 1.
- R4: Bytes pack little-endian: the lowest byte address supplies `rsp_data[7:0]`. On an 8-bit bus only `fl_data[7:0]` is used, and on a 16-bit bus the even byte is on `fl_data[7:0]`.
- R5: A 1-byte word on a 16-bit bus takes `fl_data[15:8]` when address bit 0 is 1 and `fl_data[7:0]` when it is 0. `rsp_data[31:8]` is 0 for any 1-byte word.
- R6: `req_addr[ADDR_W-1]` picks the device: 0 drives `fl_ce_n`=2'b10 and 1 drives 2'b01. Exactly one select is low while `fl_oe_n` is 0. When no bus cycle runs, `fl_ce_n`=2'b11 and `fl_oe_n`=1.
- R7: The device byte offset is `req_addr[ADDR_W-2:0]`, with its low bits cleared to the word size (bit 0 for 2-byte words, bits 1:0 for 4-byte words). On an 8-bit bus `fl_addr` = offset + cycle index. On a 16-bit bus `fl_addr` = offset/2 + cycle index.
- R8: Each bus cycle lasts `cfg_wait`+1 clocks (0 to 15 wait cycles) with `fl_addr` and `fl_oe_n` steady. Data is sampled at the end of its last clock. `rsp_valid` rises beats×(`cfg_wait`+1) clocks after the accepting edge.
- R9: The configuration, address and `req_space` are captured at acceptance. Changing them during an access has no effect. `rsp_space` returns the captured tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wsz | input | 2 | Logical word size code |
| cfg_bus16 | input | 1 | 1 = 16-bit external bus, 0 = 8-bit |
| cfg_wait | input | WAIT_W | Wait cycles per bus cycle |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with valid |
| req_addr | input | ADDR_W | Byte address, top bit selects device |
| req_space | input | SPACE_W | Memory-space tag of the requester |
| rsp_valid | output | 1 | Assembled word available |
| rsp_ready | input | 1 | Client takes the word |
| rsp_data | output | 32 | Assembled word |
| rsp_space | output | SPACE_W | Tag of the request being answered |
| fl_addr | output | ADDR_W-1 | External address (byte or halfword index) |
| fl_ce_n | output | 2 | Active-low device selects |
| fl_oe_n | output | 1 | Active-low output enable |
| fl_data | input | 16 | External read data |

## Verification
The hardest situation to reach from the ports is a change in any configuration or request pin in the middle of a multi-cycle, wait-stretched access. A wrong design would re-read those pins, for example mid-word or when it reloads the wait counter. After each accepting edge the bench drives the inverse of every config, address and tag value, so any re-read shows up as a wrong address, wrong cycle count or wrong tag. The flash model answers from a function of device and byte address that differs per device. Because of that, a lane, packing or chip-select error produces a data mismatch. The bench checks the address and selects on every clock of the access.

// File: rtl/pflash_pkg.sv
package pflash_pkg;

  typedef enum logic [1:0] {
    WSZ_1B  = 2'd0,
    WSZ_2B  = 2'd1,
    WSZ_4B  = 2'd2,
    WSZ_4BX = 2'd3
  } wsz_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUS  = 2'd1,
    ST_RESP = 2'd2
  } st_e;

  // bus cycles needed for one logical word
  function automatic logic [2:0] beats_for(input logic [1:0] wsz, input logic bus16);
    logic [2:0] n;
    case (wsz)
      WSZ_1B:  n = 3'd1;
      WSZ_2B:  n = bus16 ? 3'd1 : 3'd2;
      default: n = bus16 ? 3'd2 : 3'd4;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/pflash_seq.sv
module pflash_seq
  import pflash_pkg::*;
#(
  parameter int WAIT_W = 4,
  parameter int BEAT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [BEAT_W-1:0] nbeats,
  input  logic [WAIT_W-1:0] wait_n,
  input  logic              rsp_ready,
  output logic              idle,
  output logic              bus_act,
  output logic              rsp_pend,
  output logic              sample,
  output logic [BEAT_W-2:0] beat
);

  st_e               st;
  logic [WAIT_W-1:0] wcnt, wait_q;
  logic [BEAT_W-1:0] nb_q;
  logic [BEAT_W-2:0] beat_q;
  logic              last_beat;

  assign last_beat = ({1'b0, beat_q} == (nb_q - 1'b1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      wcnt   <= '0;
      wait_q <= '0;
      nb_q   <= '0;
      beat_q <= '0;
    end else begin
      case (st)
        ST_IDLE: if (start) begin
          st     <= ST_BUS;
          wcnt   <= wait_n;
          wait_q <= wait_n;
          nb_q   <= nbeats;
          beat_q <= '0;
        end
        ST_BUS: begin
          if (wcnt == '0) begin
            if (last_beat) st <= ST_RESP;
            else begin
              beat_q <= beat_q + 1'b1;
              wcnt   <= wait_q;
            end
          end else begin
            wcnt <= wcnt - 1'b1;
          end
        end
        ST_RESP: if (rsp_ready) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign idle     = (st == ST_IDLE);
  assign bus_act  = (st == ST_BUS);
  assign rsp_pend = (st == ST_RESP);
  assign sample   = bus_act && (wcnt == '0);
  assign beat     = beat_q;

  AST_BEAT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_act |-> ({1'b0, beat_q} < nb_q)); // R3
  AST_WAIT_HOLDS_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_act && wcnt != '0) |=> (bus_act && $stable(beat_q))); // R8

endmodule

// File: rtl/pflash_addr.sv
module pflash_addr
  import pflash_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int BEAT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        wsz_in,
  input  logic              bus16,
  input  logic              bus_act,
  input  logic [BEAT_W-2:0] beat,
  output logic [ADDR_W-2:0] fl_addr,
  output logic [1:0]        fl_ce_n,
  output logic              fl_oe_n,
  output logic              lane
);

  localparam int OFF_W = ADDR_W - 1;

  logic [ADDR_W-1:0] aligned, base_q;
  logic [OFF_W-1:0]  off, half, beat_ext;

  always_comb begin
    aligned = req_addr;
    case (wsz_in)
      WSZ_1B:  aligned = req_addr;
      WSZ_2B:  aligned[0] = 1'b0;
      default: aligned[1:0] = 2'b00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     base_q <= '0;
    else if (start) base_q <= aligned;
  end

  assign off      = base_q[OFF_W-1:0];
  assign half     = {1'b0, off[OFF_W-1:1]};
  assign beat_ext = OFF_W'(beat);
  assign fl_addr  = bus16 ? (half + beat_ext) : (off + beat_ext);
  assign fl_ce_n  = !bus_act ? 2'b11 : (base_q[ADDR_W-1] ? 2'b01 : 2'b10);
  assign fl_oe_n  = !bus_act;
  assign lane     = base_q[0];

  AST_BASE_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_act && !start) |=> $stable(base_q)); // R9

endmodule

// File: rtl/pflash_pack.sv
module pflash_pack
  import pflash_pkg::*;
#(
  parameter int BEAT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              sample,
  input  logic [BEAT_W-2:0] beat,
  input  logic              bus16,
  input  logic [1:0]        wsz,
  input  logic              lane,
  input  logic [15:0]       fl_data,
  output logic [31:0]       word
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word <= '0;
    end else if (clear) begin
      word <= '0;
    end else if (sample) begin
      if (bus16 && wsz == WSZ_1B) begin
        word[7:0] <= lane ? fl_data[15:8] : fl_data[7:0];
      end else if (bus16) begin
        if (beat[0]) word[31:16] <= fl_data;
        else         word[15:0]  <= fl_data;
      end else begin
        case (beat[1:0])
          2'd0: word[7:0]   <= fl_data[7:0];
          2'd1: word[15:8]  <= fl_data[7:0];
          2'd2: word[23:16] <= fl_data[7:0];
          default: word[31:24] <= fl_data[7:0];
        endcase
      end
    end
  end

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (word == '0)); // R5

endmodule

// File: rtl/pflash_word_rd.sv
module pflash_word_rd
  import pflash_pkg::*;
#(
  parameter int ADDR_W  = 20,
  parameter int WAIT_W  = 4,
  parameter int SPACE_W = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         cfg_wsz,
  input  logic               cfg_bus16,
  input  logic [WAIT_W-1:0]  cfg_wait,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [SPACE_W-1:0] req_space,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [31:0]        rsp_data,
  output logic [SPACE_W-1:0] rsp_space,
  output logic [ADDR_W-2:0]  fl_addr,
  output logic [1:0]         fl_ce_n,
  output logic               fl_oe_n,
  input  logic [15:0]        fl_data
);

  localparam int BEAT_W = 3;

  logic               start, idle, bus_act, rsp_pend, samp, lane;
  logic [BEAT_W-2:0]  beat;
  logic [1:0]         wsz_q;
  logic               bus16_q;
  logic [SPACE_W-1:0] space_q;

  assign start = req_valid && idle;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wsz_q   <= '0;
      bus16_q <= 1'b0;
      space_q <= '0;
    end else if (start) begin
      wsz_q   <= cfg_wsz;
      bus16_q <= cfg_bus16;
      space_q <= req_space;
    end
  end

  pflash_seq #(.WAIT_W(WAIT_W), .BEAT_W(BEAT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start),
    .nbeats(beats_for(cfg_wsz, cfg_bus16)), .wait_n(cfg_wait),
    .rsp_ready(rsp_ready), .idle(idle), .bus_act(bus_act),
    .rsp_pend(rsp_pend), .sample(samp), .beat(beat)
  );

  pflash_addr #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .start(start), .req_addr(req_addr),
    .wsz_in(cfg_wsz), .bus16(bus16_q), .bus_act(bus_act), .beat(beat),
    .fl_addr(fl_addr), .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n), .lane(lane)
  );

  pflash_pack #(.BEAT_W(BEAT_W)) u_pack (
    .clk(clk), .rst_n(rst_n), .clear(start), .sample(samp), .beat(beat),
    .bus16(bus16_q), .wsz(wsz_q), .lane(lane), .fl_data(fl_data),
    .word(rsp_data)
  );

  assign req_ready = idle;
  assign rsp_valid = rsp_pend;
  assign rsp_space = space_q;

  AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_oe_n |-> ($countones(~fl_ce_n) == 1)); // R6
  AST_IDLE_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
    fl_oe_n |-> (fl_ce_n == 2'b11)); // R6
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid || !fl_oe_n) |-> !req_ready); // R1
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data) && $stable(rsp_space))); // R2
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!fl_oe_n && !samp) |=> (!fl_oe_n && $stable(fl_addr) && $stable(fl_ce_n))); // R8
  AST_BYTE_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && wsz_q == WSZ_1B) |-> (rsp_data[31:8] == '0)); // R5

endmodule

// File: tb/pflash_word_rd_tb.sv
module pflash_word_rd_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cfg_wsz = '0;
  logic        cfg_bus16 = 1'b0;
  logic [3:0]  cfg_wait = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [19:0] req_addr = '0;
  logic [1:0]  req_space = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [31:0] rsp_data;
  logic [1:0]  rsp_space;
  logic [18:0] fl_addr;
  logic [1:0]  fl_ce_n;
  logic        fl_oe_n;
  logic [15:0] fl_data;
  logic        mdl_bus16 = 1'b0;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  pflash_word_rd u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wsz(cfg_wsz), .cfg_bus16(cfg_bus16),
    .cfg_wait(cfg_wait), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_space(req_space), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_data(rsp_data), .rsp_space(rsp_space),
    .fl_addr(fl_addr), .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n), .fl_data(fl_data)
  );

  // flash contents: a function of device and byte offset
  function automatic logic [7:0] bv(input logic dev, input logic [18:0] b);
    return b[7:0] ^ b[15:8] ^ {b[18:16], 5'b0} ^ (dev ? 8'hA5 : 8'h3C);
  endfunction

  always_comb begin
    logic dev;
    dev = (fl_ce_n == 2'b01);
    if (fl_oe_n)        fl_data = 16'hDEAD;
    else if (mdl_bus16) fl_data = {bv(dev, {fl_addr[17:0], 1'b1}), bv(dev, {fl_addr[17:0], 1'b0})};
    else                fl_data = {8'hEE, bv(dev, fl_addr)};
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // {pad, beats, delay, space, wait, bus16, wsz, addr}
  localparam logic [35:0] VEC [8] = '{
    {1'b0, 3'd4, 3'd0, 2'd0, 4'd0,  1'b0, 2'd2, 20'h00010},
    {1'b0, 3'd2, 3'd1, 2'd1, 4'd2,  1'b1, 2'd2, 20'h00123},
    {1'b0, 3'd2, 3'd0, 2'd2, 4'd1,  1'b0, 2'd1, 20'h80045},
    {1'b0, 3'd1, 3'd2, 2'd0, 4'd0,  1'b1, 2'd0, 20'h80047},
    {1'b0, 3'd1, 3'd0, 2'd1, 4'd3,  1'b1, 2'd0, 20'h00046},
    {1'b0, 3'd4, 3'd0, 2'd2, 4'd15, 1'b0, 2'd3, 20'h7FFFC},
    {1'b0, 3'd1, 3'd3, 2'd0, 4'd0,  1'b1, 2'd1, 20'h0ABCD},
    {1'b0, 3'd1, 3'd1, 2'd1, 4'd5,  1'b0, 2'd0, 20'hFFFFF}
  };

  task automatic run_vec(input logic [35:0] v);
    logic [19:0] a;  logic [1:0] wsz, sp;  logic bus;  logic [3:0] w;
    logic [2:0] dly, nb;  logic [18:0] off;  logic dev;  logic [31:0] exp, held;
    logic [18:0] expa;  logic [1:0] expce;
    int wb, k, abad, cbad, rbad, sbad;
    a = v[19:0]; wsz = v[21:20]; bus = v[22]; w = v[26:23];
    sp = v[28:27]; dly = v[31:29]; nb = v[34:32];
    wb  = (wsz == 2'd0) ? 1 : (wsz == 2'd1) ? 2 : 4;
    off = a[18:0];
    if (wb == 2) off[0] = 1'b0;
    if (wb == 4) off[1:0] = 2'b00;
    dev = a[19];
    expce = dev ? 2'b01 : 2'b10;
    exp = '0;
    for (int i = 0; i < wb; i++) exp[8*i +: 8] = bv(dev, off + 19'(i));

    @(negedge clk);
    chk(req_ready === 1'b1, "R1 ready when idle", 32'(req_ready), 32'd1);
    mdl_bus16 = bus;
    cfg_wsz = wsz; cfg_bus16 = bus; cfg_wait = w; req_addr = a; req_space = sp;
    req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    // R9: scramble every captured input during the access
    cfg_wsz = ~wsz; cfg_bus16 = ~bus; cfg_wait = ~w; req_addr = ~a; req_space = ~sp;
    k = 0; abad = 0; cbad = 0; rbad = 0;
    while (!rsp_valid && k < 400) begin
      expa = bus ? ({1'b0, off[18:1]} + 19'(k / (int'(w) + 1)))
                 : (off + 19'(k / (int'(w) + 1)));
      if (fl_addr !== expa || fl_oe_n !== 1'b0) abad++;
      if (fl_ce_n !== expce) cbad++;
      if (req_ready !== 1'b0) rbad++;
      k++;
      @(negedge clk);
    end
    chk(k == int'(nb) * (int'(w) + 1), "R3/R8 bus clocks", 32'(k), 32'(int'(nb) * (int'(w) + 1)));
    chk(abad == 0, "R7/R8 address and oe per clock", 32'(abad), 32'd0);
    chk(cbad == 0, "R6 chip select", 32'(cbad), 32'd0);
    chk(rbad == 0, "R1 not ready while busy", 32'(rbad), 32'd0);
    chk(rsp_data === exp, (wb == 1) ? "R5 byte word" : "R4 packed word", rsp_data, exp);
    chk(rsp_space === sp, "R9 space tag", 32'(rsp_space), 32'(sp));
    held = rsp_data; sbad = 0;
    for (int d = 0; d < int'(dly); d++) begin
      @(negedge clk);
      if (!rsp_valid || rsp_data !== held || rsp_space !== sp || fl_ce_n !== 2'b11) sbad++;
    end
    chk(sbad == 0, "R2 response held under back-pressure", 32'(sbad), 32'd0);
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk(rsp_valid === 1'b0 && req_ready === 1'b1 && fl_oe_n === 1'b1,
        "R2 idle after handshake", {29'd0, rsp_valid, req_ready, fl_oe_n}, 32'd3);
  endtask

  initial begin
    #(200000 * 8);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(req_ready === 1'b1 && rsp_valid === 1'b0, "R1 reset state",
        {30'd0, req_ready, rsp_valid}, 32'd2);
    chk(fl_ce_n === 2'b11 && fl_oe_n === 1'b1, "R6 reset deselect",
        {29'd0, fl_ce_n, fl_oe_n}, 32'd7);
    rst_n = 1'b1;
    for (int i = 0; i < 8; i++) run_vec(VEC[i]);

    // reset in the middle of a long access
    @(negedge clk);
    mdl_bus16 = 1'b0;
    cfg_wsz = 2'd2; cfg_bus16 = 1'b0; cfg_wait = 4'd7; req_addr = 20'h80100; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (5) @(negedge clk);
    chk(fl_ce_n === 2'b01 && fl_oe_n === 1'b0, "R6 device 1 selected mid access",
        {29'd0, fl_ce_n, fl_oe_n}, 32'd2);
    rst_n = 1'b0;
    @(negedge clk);
    chk(fl_ce_n === 2'b11 && fl_oe_n === 1'b1 && req_ready === 1'b1, "R6 reset aborts access",
        {29'd0, fl_ce_n, fl_oe_n}, 32'd7);
    rst_n = 1'b1;
    run_vec(VEC[1]);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule